// File: doc/BRIEF.md
# Configurable HDLC Frame Transmitter

This block turns a byte stream into a serial HDLC line for one channel. Packet bytes arrive on a byte-wide port with valid, start and end markers and wait in a one-byte holding register. Each cycle in which the bit strobe is high, the engine moves one bit out to the line. Between packets the line carries a repeating interfill byte. In framed mode each packet goes out inside a pair of 7Eh flags. The engine inserts a zero after every run of five ones and can append a 16-bit or 32-bit frame check sequence. In transparent mode the packet bits go out as they are, with no flags, no check sequence and no inserted zeros.

The configuration inputs select framed or transparent operation, the interfill byte, the check sequence type, inversion of the whole output and the order in which the bits of each byte are sent. The engine takes a new copy of these inputs only when an interfill byte ends, or when a frame ends and the line goes back to interfill. A frame that is already being sent keeps the settings it started with. If a frame starts in framed mode with the reserved check sequence code, no check sequence is sent and a sticky error flag is set.

Top module: `hdlc_tx_engine`

## Requirements
- R1: During reset and right after it, `txBit` is 1, `inReady` is 1 and `cfgErr` is 0. The first interfill byte after reset is 7Eh and is not inverted.
- R2: In framed mode a packet goes out as one 7Eh opening flag, then the information bits, then the check sequence if one is selected, then one 7Eh closing flag. The line then goes back to interfill, and each interfill byte starts right after the closing flag.
- R3: In framed mode a 0 is inserted after every five consecutive 1s in the information bits and the check sequence. This also applies when the run ends on the last bit before the closing flag. Flags and interfill bytes are never stuffed.
- R4: The `cfgFcsSel` code selects the check sequence: 0 means none, 1 means 16-bit, 2 means 32-bit. The 16-bit check uses x^16+x^12+x^5+1 and the 32-bit check uses the Ethernet polynomial. Both are calculated LSB-first as reflected CRCs (register shifted right, poly 8408h / EDB88320h). Both start from all ones and run over the unstuffed information bits in the order they are sent. The ones complement of the register is sent, bit 0 first.
- R5: Code 3 on `cfgFcsSel` in framed mode means that no check sequence is sent. `cfgErr` goes high when such a frame starts and stays high until reset. In transparent mode the code is ignored and `cfgErr` is not raised.
- R6: In transparent mode the packet bits go out with no flags, no check sequence and no inserted zeros. Interfill is sent between packets.
- R7: The interfill byte is 7Eh when `cfgIdleOnes` is 0 and FFh when it is 1. It is always repeated as a whole byte.
- R8: When `cfgInvert` is 1, every bit on the line is inverted. This covers flags, interfill, data, check sequence and inserted zeros.
- R9: When `cfgMsbFirst` is 0, bit 0 of each packet byte goes out first. When it is 1, bit 7 goes out first.
- R10: A configuration change made while a frame is being sent does not change that frame.
- R11: While the engine is idle, a byte taken in without `inSop` is thrown away. A frame begins only with a byte that carries `inSop`.
- R12: A byte is taken in on a cycle with `inValid` and `inReady` both high. `inReady` then stays low until the engine takes the byte. `txBit` changes only in the cycle after a cycle with `bitEn` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| bitEn | input | 1 | Line bit strobe: one output bit per high cycle |
| cfgTransparent | input | 1 | 1 = transparent, 0 = framed |
| cfgIdleOnes | input | 1 | Interfill byte: 0 = 7Eh, 1 = FFh |
| cfgFcsSel | input | 2 | Check sequence: 0 none, 1 16-bit, 2 32-bit, 3 reserved |
| cfgInvert | input | 1 | Invert the whole line output |
| cfgMsbFirst | input | 1 | Send bit 7 of each byte first |
| inData | input | BYTE_W | Packet byte |
| inValid | input | 1 | Byte valid |
| inSop | input | 1 | Byte is the first of a packet |
| inEop | input | 1 | Byte is the last of a packet |
| inReady | output | 1 | Holding register is empty |
| txBit | output | 1 | Serial line output |
| cfgErr | output | 1 | Sticky flag: a frame started with the reserved check code |

## Verification
The assertions assume that the byte source keeps up with the line. The next byte of a packet must already be waiting when the byte on the line finishes, so a frame never ends early because of an empty holding register. They also assume that no more than one start byte is pending at a time. The bench offers each byte as soon as `inReady` is seen high and pulses `bitEn` every other cycle. One packet byte lasts sixteen clocks on the line, while a handover takes about three, so the holding register is always filled in time. The only configuration changes made during a frame are the ones in the test that checks that a running frame is not affected.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  localparam int FCS16_W = 16;
  localparam int FCS32_W = 32;
  localparam logic [31:0] CRC16_POLY = 32'h0000_8408;
  localparam logic [31:0] CRC32_POLY = 32'hEDB8_8320;

  typedef enum logic [1:0] {
    FCS_NONE = 2'd0,
    FCS_16   = 2'd1,
    FCS_32   = 2'd2,
    FCS_BAD  = 2'd3
  } fcs_e;

  typedef struct packed {
    logic msbFirst;
    logic invert;
    fcs_e fcsSel;
    logic idleOnes;
    logic transparent;
  } cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPEN, ST_DATA, ST_FCS, ST_CLOSE
  } state_e;

  typedef enum logic [2:0] {
    SRC_IDLE, SRC_FLAG, SRC_DATA, SRC_FCS, SRC_STUFF
  } src_e;

  typedef struct packed {
    logic emit;
    src_e src;
    logic stuffable;
    logic loadByte;
    logic dropHold;
    logic crcInit;
    logic crcStep;
    logic fcsLoad;
    logic fcsShift;
    logic latchCfg;
    logic markErr;
  } strobe_t;

endpackage

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = $clog2(BYTE_W),
  parameter int CNT_W  = $clog2(FCS32_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             holdFull,
  input  logic             holdSop,
  input  logic             curEop,
  input  logic             onesFull,
  input  logic             startTransparent,
  input  logic             startBadFcs,
  input  logic             qTransparent,
  input  fcs_e             qFcsSel,
  output strobe_t          stb,
  output logic [IDX_W-1:0] bitIdx
);

  state_e state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic byteEnd, fcsEnd, fcsOn;

  assign byteEnd = (cnt == CNT_W'(BYTE_W - 1));
  assign fcsOn   = (qFcsSel == FCS_16) || (qFcsSel == FCS_32);
  assign fcsEnd  = (cnt == CNT_W'(((qFcsSel == FCS_32) ? FCS32_W : FCS16_W) - 1));
  assign bitIdx  = cnt[IDX_W-1:0];

  always_comb begin
    stb       = '0;
    nextState = state;
    nextCnt   = cnt;
    stb.dropHold = (state == ST_IDLE) && holdFull && !holdSop;
    if (bitEn) begin
      stb.emit = 1'b1;
      if (onesFull) begin
        stb.src = SRC_STUFF;
      end else begin
        nextCnt = cnt + 1'b1;
        unique case (state)
          ST_IDLE: begin
            stb.src = SRC_IDLE;
            if (byteEnd) begin
              nextCnt      = '0;
              stb.latchCfg = 1'b1;
              if (holdFull && holdSop) begin
                if (startTransparent) begin
                  nextState    = ST_DATA;
                  stb.loadByte = 1'b1;
                end else begin
                  nextState   = ST_OPEN;
                  stb.markErr = startBadFcs;
                end
              end
            end
          end
          ST_OPEN: begin
            stb.src = SRC_FLAG;
            if (byteEnd) begin
              nextCnt      = '0;
              nextState    = ST_DATA;
              stb.loadByte = 1'b1;
              stb.crcInit  = 1'b1;
            end
          end
          ST_DATA: begin
            stb.src       = SRC_DATA;
            stb.stuffable = !qTransparent;
            stb.crcStep   = !qTransparent;
            if (byteEnd) begin
              nextCnt = '0;
              if (!curEop && holdFull) begin
                stb.loadByte = 1'b1;
              end else if (qTransparent) begin
                nextState    = ST_IDLE;
                stb.latchCfg = 1'b1;
              end else if (fcsOn) begin
                nextState   = ST_FCS;
                stb.fcsLoad = 1'b1;
              end else begin
                nextState = ST_CLOSE;
              end
            end
          end
          ST_FCS: begin
            stb.src       = SRC_FCS;
            stb.stuffable = 1'b1;
            stb.fcsShift  = 1'b1;
            if (fcsEnd) begin
              nextCnt   = '0;
              nextState = ST_CLOSE;
            end
          end
          ST_CLOSE: begin
            stb.src = SRC_FLAG;
            if (byteEnd) begin
              nextCnt      = '0;
              nextState    = ST_IDLE;
              stb.latchCfg = 1'b1;
            end
          end
          default: begin
            nextCnt   = '0;
            nextState = ST_IDLE;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end

endmodule

// File: rtl/hdlc_tx_dp.sv
module hdlc_tx_dp
  import hdlc_tx_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int STUFF_LIMIT = 5,
  parameter int IDX_W       = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [IDX_W-1:0]  bitIdx,
  input  cfg_t              cfgIn,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  input  logic              inSop,
  input  logic              inEop,
  output logic              inReady,
  output logic              holdFull,
  output logic              holdSop,
  output logic              curEop,
  output logic              onesFull,
  output cfg_t              cfgQ,
  output logic              txBit,
  output logic              cfgErr
);

  localparam int ONES_W = $clog2(STUFF_LIMIT + 1);
  localparam logic [BYTE_W-1:0] FLAG_PAT = {1'b0, {(BYTE_W-2){1'b1}}, 1'b0};

  logic [BYTE_W-1:0] holdData, curByte;
  logic              holdEop;
  logic [31:0]       crc, crcAfter, fcsReg;
  logic [ONES_W-1:0] ones;
  logic [IDX_W-1:0]  dataIdx;
  logic              rawBit, fb, sel32;

  assign inReady  = !holdFull;
  assign onesFull = (ones == ONES_W'(STUFF_LIMIT));
  assign dataIdx  = cfgQ.msbFirst ? (IDX_W'(BYTE_W - 1) - bitIdx) : bitIdx;
  assign sel32    = (cfgQ.fcsSel == FCS_32);

  always_comb begin
    unique case (stb.src)
      SRC_IDLE: rawBit = cfgQ.idleOnes | FLAG_PAT[bitIdx];
      SRC_FLAG: rawBit = FLAG_PAT[bitIdx];
      SRC_DATA: rawBit = curByte[dataIdx];
      SRC_FCS:  rawBit = fcsReg[0];
      default:  rawBit = 1'b0;
    endcase
  end

  assign fb = crc[0] ^ rawBit;

  always_comb begin
    if (sel32) crcAfter = {1'b0, crc[31:1]} ^ (fb ? CRC32_POLY : 32'h0);
    else       crcAfter = {17'h0, crc[15:1]} ^ (fb ? CRC16_POLY : 32'h0);
  end

  // holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      holdSop  <= 1'b0;
      holdEop  <= 1'b0;
      holdData <= '0;
    end else if (inValid && !holdFull) begin
      holdFull <= 1'b1;
      holdSop  <= inSop;
      holdEop  <= inEop;
      holdData <= inData;
    end else if (stb.loadByte || stb.dropHold) begin
      holdFull <= 1'b0;
    end
  end

  // line byte, check sequence, stuffing run, configuration copy, output
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curByte <= '0;
      curEop  <= 1'b0;
      crc     <= '1;
      fcsReg  <= '0;
      ones    <= '0;
      cfgQ    <= '0;
      txBit   <= 1'b1;
      cfgErr  <= 1'b0;
    end else begin
      if (stb.loadByte) begin
        curByte <= holdData;
        curEop  <= holdEop;
      end
      if (stb.crcInit)      crc <= '1;
      else if (stb.crcStep) crc <= crcAfter;
      if (stb.fcsLoad)       fcsReg <= ~crcAfter;
      else if (stb.fcsShift) fcsReg <= {1'b0, fcsReg[31:1]};
      if (stb.emit) begin
        txBit <= rawBit ^ cfgQ.invert;
        ones  <= (stb.stuffable && rawBit) ? ones + 1'b1 : '0;
      end
      if (stb.latchCfg) cfgQ <= cfgIn;
      if (stb.markErr)  cfgErr <= 1'b1;
    end
  end

endmodule

// File: rtl/hdlc_tx_engine.sv
module hdlc_tx_engine
  import hdlc_tx_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int STUFF_LIMIT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              cfgTransparent,
  input  logic              cfgIdleOnes,
  input  logic [1:0]        cfgFcsSel,
  input  logic              cfgInvert,
  input  logic              cfgMsbFirst,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  input  logic              inSop,
  input  logic              inEop,
  output logic              inReady,
  output logic              txBit,
  output logic              cfgErr
);

  localparam int IDX_W = $clog2(BYTE_W);
  localparam int CNT_W = $clog2(FCS32_W);

  cfg_t             cfgIn, cfgQ;
  strobe_t          stb;
  logic [IDX_W-1:0] bitIdx;
  logic             holdFull, holdSop, curEop, onesFull;

  assign cfgIn = '{msbFirst: cfgMsbFirst, invert: cfgInvert, fcsSel: fcs_e'(cfgFcsSel),
                   idleOnes: cfgIdleOnes, transparent: cfgTransparent};

  hdlc_tx_ctrl #(.BYTE_W(BYTE_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn),
    .holdFull(holdFull), .holdSop(holdSop), .curEop(curEop), .onesFull(onesFull),
    .startTransparent(cfgIn.transparent), .startBadFcs(cfgIn.fcsSel == FCS_BAD),
    .qTransparent(cfgQ.transparent), .qFcsSel(cfgQ.fcsSel),
    .stb(stb), .bitIdx(bitIdx)
  );

  hdlc_tx_dp #(.BYTE_W(BYTE_W), .STUFF_LIMIT(STUFF_LIMIT), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .bitIdx(bitIdx), .cfgIn(cfgIn),
    .inData(inData), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .inReady(inReady), .holdFull(holdFull), .holdSop(holdSop), .curEop(curEop),
    .onesFull(onesFull), .cfgQ(cfgQ), .txBit(txBit), .cfgErr(cfgErr)
  );

endmodule

// File: rtl/hdlc_tx_chk.sv
module hdlc_tx_chk
  import hdlc_tx_pkg::*;
#(
  parameter int STUFF_LIMIT = 5
) (
  input logic    clk,
  input logic    rstN,
  input logic    bitEn,
  input logic    txBit,
  input logic    inReady,
  input logic    inValid,
  input logic    cfgErr,
  input cfg_t    cfgQ,
  input strobe_t stb
);

  localparam int RUN_W = $clog2(STUFF_LIMIT + 2) + 1;

  logic             lastEmit, lastStuffable;
  logic [RUN_W-1:0] run;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastEmit      <= 1'b0;
      lastStuffable <= 1'b0;
      run           <= '0;
    end else begin
      lastEmit      <= stb.emit;
      lastStuffable <= stb.emit && stb.stuffable;
      if (lastEmit) begin
        if (lastStuffable && (txBit ^ cfgQ.invert)) run <= run + 1'b1;
        else                                        run <= '0;
      end
    end
  end

  // R3: no run of stuffable ones longer than the limit reaches the line
  a_r3_run_limit: assert property (@(posedge clk) disable iff (!rstN)
    run <= RUN_W'(STUFF_LIMIT));

  // R12: line output only moves after a strobe
  a_r12_hold_bit: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(txBit));

  // R12: an accepted byte closes the input
  a_r12_ready_fill: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // R5: error flag is sticky
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);

  // R6: transparent mode emits neither flags, check bits nor inserted zeros
  a_r6_no_framing: assert property (@(posedge clk) disable iff (!rstN)
    (stb.emit && cfgQ.transparent) |-> (stb.src == SRC_IDLE || stb.src == SRC_DATA));

  // R10: configuration copy stays put while check bits are going out
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (stb.emit && stb.src == SRC_FCS) |=> $stable(cfgQ));

endmodule

bind hdlc_tx_engine hdlc_tx_chk #(.STUFF_LIMIT(STUFF_LIMIT)) uChk (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .txBit(txBit), .inReady(inReady),
  .inValid(inValid), .cfgErr(cfgErr), .cfgQ(cfgQ), .stb(stb)
);

// File: tb/sim_hdlc_tx_engine.sv
module sim_hdlc_tx_engine;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN = 1'b0, bitEn = 1'b0;
  logic       cfgTransparent = 1'b0, cfgIdleOnes = 1'b0, cfgInvert = 1'b0, cfgMsbFirst = 1'b0;
  logic [1:0] cfgFcsSel = 2'd0;
  logic [7:0] inData = 8'h00;
  logic       inValid = 1'b0, inSop = 1'b0, inEop = 1'b0;
  logic       inReady, txBit, cfgErr;

  hdlc_tx_engine u0 (
    .clk(clk), .rstN(rstN), .bitEn(bitEn),
    .cfgTransparent(cfgTransparent), .cfgIdleOnes(cfgIdleOnes), .cfgFcsSel(cfgFcsSel),
    .cfgInvert(cfgInvert), .cfgMsbFirst(cfgMsbFirst),
    .inData(inData), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .inReady(inReady), .txBit(txBit), .cfgErr(cfgErr)
  );

  int nChecks = 0, nFails = 0;
  bit cap [0:1023];
  bit expb [0:1023];
  int capN = 0, expN = 0, run = 0;
  bit capOn = 0, genOn = 0;
  logic [7:0] pkt [0:7];
  bit curIdl, curInv;

  // capture the bit produced by the previous strobe, then move the strobe
  always @(negedge clk) begin
    if (capOn && bitEn && capN < 1024) begin
      cap[capN] = txBit;
      capN++;
    end
    bitEn = genOn ? ~bitEn : 1'b0;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crcStep(input logic [31:0] c, input bit b, input bit w32);
    bit f = c[0] ^ b;
    if (w32) return (c >> 1) ^ (f ? 32'hEDB88320 : 32'h0);
    return ({16'h0, c[15:0]} >> 1) ^ (f ? 32'h00008408 : 32'h0);
  endfunction

  function automatic bit flagBit(input int i);
    return !(i == 0 || i == 7);
  endfunction

  function automatic bit idleBit(input int i);
    return (curIdl ? 1'b1 : flagBit(i % 8)) ^ curInv;
  endfunction

  task automatic pushRaw(input bit b);
    expb[expN] = b;
    expN++;
  endtask

  task automatic pushStuffed(input bit b);
    pushRaw(b);
    run = b ? run + 1 : 0;
    if (run == 5) begin
      pushRaw(1'b0);
      run = 0;
    end
  endtask

  task automatic buildFrame(input bit tr, input bit [1:0] fcs, input bit inv, input bit msb, input int len);
    logic [31:0] c = '1;
    logic [31:0] f;
    expN = 0;
    run = 0;
    if (!tr) for (int i = 0; i < 8; i++) pushRaw(flagBit(i));
    for (int j = 0; j < len; j++)
      for (int i = 0; i < 8; i++) begin
        bit b = pkt[j][msb ? 7 - i : i];
        if (tr) pushRaw(b);
        else begin
          pushStuffed(b);
          c = crcStep(c, b, fcs == 2'd2);
        end
      end
    if (!tr && (fcs == 2'd1 || fcs == 2'd2)) begin
      f = ~c;
      for (int i = 0; i < ((fcs == 2'd2) ? 32 : 16); i++) pushStuffed(f[i]);
    end
    if (!tr) for (int i = 0; i < 8; i++) pushRaw(flagBit(i));
    for (int i = 0; i < expN; i++) expb[i] = expb[i] ^ inv;
  endtask

  task automatic doReset();
    genOn = 0;
    capOn = 0;
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    capN = 0;
    capOn = 1;
    genOn = 1;
  endtask

  task automatic sendByte(input logic [7:0] d, input bit sop, input bit eop);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inData = d;
    inSop = sop;
    inEop = eop;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic sendPacket(input int len);
    for (int j = 0; j < len; j++) sendByte(pkt[j], j == 0, j == len - 1);
  endtask

  task automatic checkStream(input bit trail, input string tag);
    bit good = 0;
    int firstBad = -1;
    for (int i = 0; i < 8; i++)
      if (cap[i] != flagBit(i) && firstBad < 0) firstBad = i;
    if (firstBad < 0)
      for (int k = 0; k < 4 && !good; k++) begin
        bit ok = 1;
        int base = 8 + 8 * k;
        for (int p = 8; p < base; p++) if (cap[p] != idleBit(p)) ok = 0;
        for (int i = 0; i < expN; i++) if (cap[base + i] != expb[i]) ok = 0;
        if (trail)
          for (int t = 0; t < 16; t++) if (cap[base + expN + t] != idleBit(t)) ok = 0;
        good = ok;
      end
    if (!good && firstBad < 0)
      for (int i = 0; i < expN; i++)
        if (cap[8 + i] != expb[i] && firstBad < 0) firstBad = 8 + i;
    if (firstBad < 0) firstBad = 0;
    check(good, tag, $sformatf("line stream bit %0d (first frame mismatch)", firstBad),
          int'(cap[firstBad]), firstBad >= 8 ? int'(expb[firstBad - 8]) : int'(flagBit(firstBad)));
  endtask

  // mode 0: plain, 1: change config mid-frame, 2: stray non-start byte first
  task automatic runCase(input bit tr, input bit idl, input bit [1:0] fcs, input bit inv,
                         input bit msb, input int len, input int mode, input string tag);
    cfgTransparent = tr;
    cfgIdleOnes = idl;
    cfgFcsSel = fcs;
    cfgInvert = inv;
    cfgMsbFirst = msb;
    curIdl = idl;
    curInv = inv;
    buildFrame(tr, fcs, inv, msb, len);
    doReset();
    fork
      begin
        if (mode == 2) sendByte(8'hA5, 1'b0, 1'b0);
        sendPacket(len);
      end
      begin
        if (mode == 1) begin
          wait (capN >= 20);
          @(negedge clk);
          cfgInvert = ~inv;
          cfgMsbFirst = ~msb;
          cfgIdleOnes = ~idl;
        end
      end
    join
    wait (capN >= expN + 72);
    capOn = 0;
    genOn = 0;
    checkStream(mode != 1, tag);
    check(cfgErr == (!tr && fcs == 2'd3), "R5", "sticky config error flag",
          int'(cfgErr), int'(!tr && fcs == 2'd3));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(txBit == 1'b1, "R1", "txBit in reset", int'(txBit), 1);
    check(inReady == 1'b1, "R1", "inReady in reset", int'(inReady), 1);
    check(cfgErr == 1'b0, "R1", "cfgErr in reset", int'(cfgErr), 0);

    // R12: byte held while no strobe arrives
    rstN = 1'b1;
    @(negedge clk);
    inData = 8'h3C; inSop = 1'b1; inEop = 1'b1; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(inReady == 1'b0, "R12", "inReady after accept", int'(inReady), 0);
    repeat (10) @(negedge clk);
    check(inReady == 1'b0, "R12", "inReady held without strobe", int'(inReady), 0);
    check(txBit == 1'b1, "R12", "txBit without strobe", int'(txBit), 1);

    // sweep over every configuration
    for (int idx = 0; idx < 64; idx++) begin
      bit tr = idx[0], idl = idx[1], inv = idx[4], msb = idx[5];
      bit [1:0] fcs = idx[3:2];
      int len = 1 + (idx % 4);
      for (int j = 0; j < len; j++)
        pkt[j] = ((idx + j) % 3 == 0) ? 8'hFF : 8'((idx * 37 + j * 91) ^ 8'hB3);
      runCase(tr, idl, fcs, inv, msb, len, 0,
              $sformatf("R7 R8 R9 %s", tr ? "R6" : (fcs == 2'd3 ? "R5 R3" : "R2 R3 R4")));
    end

    // R3: run of ones ending exactly at the end of the data, no check sequence
    pkt[0] = 8'hF8; pkt[1] = 8'hFF;
    runCase(1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 2, 0, "R3");

    // R10: configuration changed while a frame is on the line
    pkt[0] = 8'h81; pkt[1] = 8'hFF; pkt[2] = 8'h0F; pkt[3] = 8'h5A;
    runCase(1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 4, 1, "R10");
    runCase(1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 4, 1, "R10");

    // R11: stray byte without start marker while idle
    pkt[0] = 8'h7E; pkt[1] = 8'h1F;
    runCase(1'b0, 1'b1, 2'd2, 1'b0, 1'b1, 2, 2, "R11");
    runCase(1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 2, 2, "R11");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule